// File: doc/BRIEF.md
# Late-Capture Timing-Error Register

This block is a pipeline register that catches setup-time failures of the logic stage in front of it and repairs them locally. Its main register takes `d` on the rising edge of `clk`. A shadow register takes the same `d` again on the rising edge of `clk_del`, a fixed delay later, when slow logic has had time to settle. When the two copies differ, the stage was too slow. The register then reloads its output from the shadow copy and sends a one-cycle error pulse to the pipeline control.

The error pulse and a saturating error count go to a supply-voltage controller. The controller uses them to tell that the operating point is too aggressive. A stall request shares the cycle with the repaired output, so that upstream stages hold their data while the register spends one cycle on the repair. Replay, stall handling and voltage control belong to the surrounding design.

Top module: `late_capture_reg`

## Requirements
- R1: Outside a repair, `q` shows the value of `d` that the main register sampled at the last rising `clk` edge.
- R2: The shadow register samples `d` on every rising `clk_del` edge. A difference in any single bit between the shadow value and the main value, compared before the next `clk` edge, counts as a timing error.
- R3: A timing error detected in one cycle raises `err_pulse` for exactly one cycle, starting at the next rising `clk` edge.
- R4: On the edge that raises `err_pulse`, the main register loads the shadow value and not `d`, so `q` carries the corrected data for that cycle.
- R5: `stall_req` is high in exactly the cycles in which `err_pulse` is high.
- R6: Each timing error raises `err_count` by one on the same edge that raises `err_pulse`.
- R7: `err_count` saturates at 2^CNT_W-1 and does not wrap.
- R8: While `rst_n` is low at a `clk` edge, `q`, `err_pulse`, `stall_req` and `err_count` clear to 0. No error is reported on the first edge after reset, even if the shadow register already holds a different value.
- R9: During a repair cycle the comparison is ignored, so the edge that follows a repair never raises `err_pulse`, whatever `d` does in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; rising edge samples the main register |
| clk_del | input | 1 | Delayed copy of clk; rising edge samples the shadow register |
| rst_n | input | 1 | Synchronous active-low reset |
| d | input | WIDTH | Data from the logic stage |
| q | output | WIDTH | Registered, possibly corrected data |
| err_pulse | output | 1 | One-cycle timing-error indication |
| stall_req | output | 1 | Hold request to upstream for the repair cycle |
| err_count | output | CNT_W | Saturating count of timing errors |

## Verification
A corrupted shadow bit shows up at the ports one edge later, as a spurious `err_pulse` together with a wrong `q`. A stuck control state shows up either as an error pulse wider than one cycle or as a repair that leaves `q` equal to the late-missed value instead of the corrected one. The bench drives late data by changing `d` between the `clk` and `clk_del` edges, and it checks `q`, the pulse, the stall and the count on the cycle right after each such event. This exposes any internal fault within a single cycle. Counter faults appear as a skipped or wrapped count at the saturation boundary.

// File: rtl/lcr_pkg.sv
// Shared types for the late-capture timing-error register.
// Assumes: nothing beyond standard SystemVerilog.
package lcr_pkg;

    // Phase of the error control: just out of reset, normal run, or repair.
    typedef enum logic [1:0] {
        PH_COLD = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIX  = 2'd2
    } lcr_phase_e;

endpackage

// File: rtl/lcr_shadow_bank.sv
// Shadow register bank: samples the data again on the delayed clock.
// Assumes: clk_del is a fixed delay after clk, so a rising clk_del edge
// falls inside the same clk cycle; rst_n is sampled on clk_del.
module lcr_shadow_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk_del,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] shadow_q
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic bit_r;
            // One shadow bit, sampled late.
            always_ff @(posedge clk_del) begin
                if (!rst_n) bit_r <= 1'b0;
                else        bit_r <= d[gi];
            end
            assign shadow_q[gi] = bit_r;
        end
    endgenerate

endmodule

// File: rtl/lcr_compare.sv
// Per-bit comparator between the main and shadow copies, reduced to one flag.
// Assumes: both inputs are stable between the clk_del edge and the next clk edge.
module lcr_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] main_q,
    input  logic [WIDTH-1:0] shadow_q,
    output logic             mismatch
);

    logic [WIDTH-1:0] diff_bits;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_diff
            assign diff_bits[gi] = main_q[gi] ^ shadow_q[gi];
        end
    endgenerate

    // Any differing bit is a timing error.
    always_comb mismatch = |diff_bits;

endmodule

// File: rtl/lcr_err_ctrl.sv
// Error control: decides when to repair, and drives the pulse and stall outputs.
// Assumes: mismatch is only meaningful once the main register has captured
// a non-reset sample, and is meaningless during a repair cycle.
module lcr_err_ctrl
    import lcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic fix_now,
    output logic err_pulse,
    output logic stall_req
);

    lcr_phase_e phase, phase_nx;
    logic       err_q;
    logic       stall_q;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_COLD: phase_nx = PH_RUN;
            PH_RUN:  phase_nx = mismatch ? PH_FIX : PH_RUN;
            PH_FIX:  phase_nx = PH_RUN;
            default: phase_nx = PH_COLD;
        endcase
    end

    // Repair is taken only from the run phase.
    assign fix_now = (phase == PH_RUN) && mismatch;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_COLD;
        else        phase <= phase_nx;
    end

    // Error pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= fix_now;
    end

    // Stall request register, derived from the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= (phase_nx == PH_FIX);
    end

    assign err_pulse = err_q;
    assign stall_req = stall_q;

endmodule

// File: rtl/lcr_sat_counter.sv
// Saturating event counter for the voltage controller.
// Assumes: inc is a single-cycle request in the clk domain.
module lcr_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count up, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (inc && count != CNT_MAX)  count <= count + 1'b1;
    end

endmodule

// File: rtl/late_capture_reg.sv
// Late-capture timing-error register: main register on clk, shadow on clk_del,
// compare, repair from the shadow copy, and report.
// Assumes: clk_del rises a fixed delay after clk, within the same cycle;
// rst_n is synchronous and active low in both clock domains.
module late_capture_reg #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             clk_del,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             err_pulse,
    output logic             stall_req,
    output logic [CNT_W-1:0] err_count
);

    logic [WIDTH-1:0] main_q;
    logic [WIDTH-1:0] shadow_q;
    logic             mismatch;
    logic             fix_now;

    lcr_shadow_bank #(.WIDTH(WIDTH)) u_shadow (
        .clk_del  (clk_del),
        .rst_n    (rst_n),
        .d        (d),
        .shadow_q (shadow_q)
    );

    lcr_compare #(.WIDTH(WIDTH)) u_cmp (
        .main_q   (main_q),
        .shadow_q (shadow_q),
        .mismatch (mismatch)
    );

    lcr_err_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mismatch  (mismatch),
        .fix_now   (fix_now),
        .err_pulse (err_pulse),
        .stall_req (stall_req)
    );

    lcr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fix_now),
        .count (err_count)
    );

    // Main register with the repair multiplexer in front.
    always_ff @(posedge clk) begin
        if (!rst_n) main_q <= '0;
        else        main_q <= fix_now ? shadow_q : d;
    end

    assign q = main_q;

endmodule

// File: rtl/lcr_checker.sv
// Property checker for late_capture_reg, attached by bind.
// Assumes: sampled on clk; shadow_q is the internal shadow copy.
module lcr_checker #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] shadow_q,
    input logic             err_pulse,
    input logic             stall_req,
    input logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !err_pulse) |-> (q == $past(d)));

    p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    p_fix_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_pulse) |-> (q == $past(shadow_q)));

    p_stall_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req == err_pulse);

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_pulse && $past(err_count) != CNT_MAX)
        |-> (err_count == CNT_W'($past(err_count) + 1'b1)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (err_count >= $past(err_count)));

    p_quiet_after_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> !err_pulse);

endmodule

bind late_capture_reg lcr_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .d         (d),
    .q         (q),
    .shadow_q  (shadow_q),
    .err_pulse (err_pulse),
    .stall_req (stall_req),
    .err_count (err_count)
);

// File: tb/tb_late_capture_reg.sv
`timescale 1ns/1ps
// Bench for late_capture_reg: a vector table walked by one loop, then
// directed saturation and reset corner tests.
module tb_late_capture_reg;

    localparam int WIDTH = 8;
    localparam int CNT_W = 4;
    localparam int NVEC  = 12;

    logic             clk;
    logic             clk_del;
    logic             rst_n;
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] q;
    logic             err_pulse;
    logic             stall_req;
    logic [CNT_W-1:0] err_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    late_capture_reg #(.WIDTH(WIDTH), .CNT_W(CNT_W)) dut (
        .clk       (clk),
        .clk_del   (clk_del),
        .rst_n     (rst_n),
        .d         (d),
        .q         (q),
        .err_pulse (err_pulse),
        .stall_req (stall_req),
        .err_count (err_count)
    );

    // 125 MHz main clock; clk rises at 4, 12, 20 ns ...
    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Delayed clock, rising 3 ns after clk.
    initial begin
        clk_del = 1'b0;
        #7;
        forever begin
            clk_del = 1'b1;
            #4;
            clk_del = 1'b0;
            #4;
        end
    end

    // Row layout: [39:32] early d, [31:24] late d, [23:20] late flag,
    // [19:12] expected q, [11:8] expected error, [7:0] expected count.
    localparam logic [39:0] VEC [NVEC] = '{
        40'h11_00_0_11_0_00,  // R1 plain load
        40'h22_00_0_22_0_00,  // R1
        40'h33_3C_1_33_0_00,  // R2 late change, q still early value
        40'h44_00_0_3C_1_01,  // R3 R4 R6 repair
        40'h44_00_0_44_0_01,  // R9 comparison ignored in repair cycle
        40'h55_5A_1_55_0_01,
        40'h66_6F_1_5A_1_02,  // R4 repair; late change in repair cycle
        40'h66_00_0_66_0_02,  // R9 late change during repair ignored
        40'h77_00_0_77_0_02,
        40'h80_81_1_80_0_02,  // R2 single-bit late change
        40'h90_00_0_81_1_03,  // R2 R4 single-bit repair
        40'h90_00_0_90_0_03
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle: early value before the clk edge, optional late value
    // between clk and clk_del; returns 5 ns after the clk edge.
    task automatic step(input logic [WIDTH-1:0] early,
                        input logic [WIDTH-1:0] late_v, input bit late);
        d = early;
        @(posedge clk);
        #1;
        if (late) d = late_v;
        @(posedge clk_del);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        d     = '0;
        repeat (3) @(posedge clk);
        @(posedge clk_del);
        #2;
        check("R8", "q after reset", 32'(q), 32'h0);
        check("R8", "err after reset", 32'(err_pulse), 32'h0);
        check("R8", "stall after reset", 32'(stall_req), 32'h0);
        check("R8", "count after reset", 32'(err_count), 32'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][39:32], VEC[i][31:24], VEC[i][20]);
            check("R1/R4", $sformatf("vec %0d q", i), 32'(q), 32'(VEC[i][19:12]));
            check("R3", $sformatf("vec %0d err", i), 32'(err_pulse), 32'(VEC[i][8]));
            check("R5", $sformatf("vec %0d stall", i), 32'(stall_req), 32'(VEC[i][8]));
            check("R6", $sformatf("vec %0d count", i), 32'(err_count), 32'(VEC[i][7:0]));
        end

        // Saturation: drive repeated errors past the counter limit (R7).
        for (int i = 0; i < 14; i++) begin
            step(8'(i * 3 + 1), 8'(i * 3 + 2), 1'b1);
            step(8'h00, 8'h00, 1'b0);
            check("R3", "sat loop err", 32'(err_pulse), 32'h1);
            check("R4", "sat loop q", 32'(q), 32'(8'(i * 3 + 2)));
            check("R7", "sat loop count", 32'(err_count),
                  (4 + i > 15) ? 32'd15 : 32'(4 + i));
        end

        // Reset in mid-run clears the state (R8).
        rst_n = 1'b0;
        step(8'hAA, 8'h00, 1'b0);
        check("R8", "q in reset", 32'(q), 32'h0);
        check("R8", "count in reset", 32'(err_count), 32'h0);
        // Release between clk and clk_del, so the shadow copy differs.
        d = 8'hAA;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        d = 8'hBB;
        @(posedge clk_del);
        #2;
        step(8'hCC, 8'h00, 1'b0);
        check("R8", "no error first edge after reset", 32'(err_pulse), 32'h0);
        check("R8", "q first edge after reset", 32'(q), 32'hCC);
        check("R8", "count first edge after reset", 32'(err_count), 32'h0);
        step(8'hDD, 8'h00, 1'b0);
        check("R1", "q after reset run", 32'(q), 32'hDD);
        check("R2", "no error on matching copies", 32'(err_pulse), 32'h0);

        finish_run();
    end

endmodule